// File: doc/BRIEF.md
# Shared Completion Interrupt Controller

The block gathers transfer-completion events from a DMA engine into one 64-bit pending vector. Each event carries a 6-bit completion code that names the bit to set. Eight requester regions and one global port read the vector through small single-cycle register ports. The vector is read as two 32-bit words, a low word and a high word.

Software clears a pending bit by writing a 1 to it in a clear register. A bit written as 0 is left alone, so requesters that own different bits never disturb each other. Each region has its own 64-bit enable mask and its own interrupt line. A global enable mask gates every region. When several ports write clear registers in the same cycle, all of the clears take effect. A pending bit moves from one value to the other on a single clock edge, so it cannot flicker while it is being cleared.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: The pending vector has 64 bits and is zero after reset. Each port reads bits 31:0 at address 0 and bits 63:32 at address 1.
- R2: A write to address 0 or 1 leaves the pending vector unchanged.
- R3: A write to address 2 clears the pending bits 31:0 whose data bits are 1. A write to address 3 does the same for bits 63:32. Bits written as 0 keep their value.
- R4: When `evt_valid` is high at a clock edge, pending bit `evt_code` is 1 after that edge.
- R5: If an event and a clear target the same bit in one cycle, the bit stays pending.
- R6: `irq[r]` is a register. At each edge it loads the OR over all bits of (pending AND region r enable AND global enable), using the values held before that edge. It therefore rises or falls one cycle after the qualifying state changes.
- R7: Each region port holds its own enable mask, and the global port holds the global enable mask. Each mask is written and read at address 4 (bits 31:0) and address 5 (bits 63:32), and is zero after reset. A write through one port changes no other port's mask.
- R8: Clear writes from any number of ports in the same cycle all take effect together.
- R9: Reads at addresses 2, 3, 6 and 7 return zero, and writes to addresses 6 and 7 have no effect.
- R10: A pending bit falls only in a cycle that has a clear write, and it rises only in a cycle that has an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Completion event strobe |
| evt_code | input | 6 | Completion code; names the bit to set |
| rg_wr | input | 8 | Write strobe, one per region |
| rg_addr | input | 24 | 3-bit register address per region, region r at [3r+2:3r] |
| rg_wdata | input | 256 | 32-bit write data per region, region r at [32r+31:32r] |
| rg_rdata | output | 256 | 32-bit read data per region, combinational from address |
| gl_wr | input | 1 | Global port write strobe |
| gl_addr | input | 3 | Global port register address |
| gl_wdata | input | 32 | Global port write data |
| gl_rdata | output | 32 | Global port read data |
| irq | output | 8 | Registered interrupt line per region |

## Verification
The bench drives an event and a clear at the same bit in one cycle. A design where the clear wins would drop a completion that really happened. It also fires clears from two regions and the global port in one cycle. A design that takes only one writer per cycle would leave bits pending that software had already cleared. Writes of mixed ones and zeros check that a zero bit preserves state, which a plain store instead of clear-on-one would break. The interrupt lines are compared against a model every cycle, so an unregistered or unqualified output shows up one cycle early or with the wrong mask.

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl #(
  parameter int NREG   = 8,
  parameter int CODE_W = 6,
  parameter int AW     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        evt_valid,
  input  logic [CODE_W-1:0]           evt_code,
  input  logic [NREG-1:0]             rg_wr,
  input  logic [NREG*AW-1:0]          rg_addr,
  input  logic [NREG*(2**CODE_W/2)-1:0] rg_wdata,
  output logic [NREG*(2**CODE_W/2)-1:0] rg_rdata,
  input  logic                        gl_wr,
  input  logic [AW-1:0]               gl_addr,
  input  logic [2**CODE_W/2-1:0]      gl_wdata,
  output logic [2**CODE_W/2-1:0]      gl_rdata,
  output logic [NREG-1:0]             irq
);
  localparam int NBIT = 2**CODE_W;
  localparam int DW   = NBIT/2;
  localparam logic [AW-1:0] A_PLO = AW'(0), A_PHI = AW'(1), A_CLO = AW'(2),
                            A_CHI = AW'(3), A_ELO = AW'(4), A_EHI = AW'(5);

  logic [NBIT-1:0] pend_q, gen_q, clr_all, set_v;
  logic [NBIT-1:0] en_q [NREG];
  logic [NREG-1:0] irq_q;

  function automatic logic [NBIT-1:0] clr_mask(input logic wr, input logic [AW-1:0] a,
                                               input logic [DW-1:0] d);
    if (wr && a == A_CLO) return {{DW{1'b0}}, d};
    if (wr && a == A_CHI) return {d, {DW{1'b0}}};
    return '0;
  endfunction

  function automatic logic [DW-1:0] rd_word(input logic [AW-1:0] a, input logic [NBIT-1:0] p,
                                            input logic [NBIT-1:0] e);
    case (a)
      A_PLO:   return p[DW-1:0];
      A_PHI:   return p[NBIT-1:DW];
      A_ELO:   return e[DW-1:0];
      A_EHI:   return e[NBIT-1:DW];
      default: return '0;
    endcase
  endfunction

  always_comb begin
    clr_all = clr_mask(gl_wr, gl_addr, gl_wdata);
    for (int r = 0; r < NREG; r++)
      clr_all |= clr_mask(rg_wr[r], rg_addr[r*AW +: AW], rg_wdata[r*DW +: DW]);
  end

  assign set_v = evt_valid ? ({{(NBIT-1){1'b0}}, 1'b1} << evt_code) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_all) | set_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        gen_q <= '0;
    else if (gl_wr && gl_addr == A_ELO) gen_q[DW-1:0]    <= gl_wdata;
    else if (gl_wr && gl_addr == A_EHI) gen_q[NBIT-1:DW] <= gl_wdata;
  end

  assign gl_rdata = rd_word(gl_addr, pend_q, gen_q);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    wire          wr = rg_wr[r];
    wire [AW-1:0] a  = rg_addr[r*AW +: AW];
    wire [DW-1:0] d  = rg_wdata[r*DW +: DW];

    always_ff @(posedge clk) begin
      if (!rst_n)               en_q[r] <= '0;
      else if (wr && a == A_ELO) en_q[r][DW-1:0]    <= d;
      else if (wr && a == A_EHI) en_q[r][NBIT-1:DW] <= d;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[r] <= 1'b0;
      else        irq_q[r] <= |(pend_q & en_q[r] & gen_q);
    end

    assign rg_rdata[r*DW +: DW] = rd_word(a, pend_q, en_q[r]);
  end

  assign irq = irq_q;
endmodule

// File: rtl/cmpl_irq_ctrl_chk.sv
module cmpl_irq_ctrl_chk #(
  parameter int NREG   = 8,
  parameter int CODE_W = 6,
  parameter int AW     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 evt_valid,
  input logic [CODE_W-1:0]    evt_code,
  input logic [NREG-1:0]      rg_wr,
  input logic [NREG*AW-1:0]   rg_addr,
  input logic                 gl_wr,
  input logic [AW-1:0]        gl_addr,
  input logic [NREG-1:0]      irq,
  input logic [2**CODE_W-1:0] pend
);
  logic any_clr;
  always_comb begin
    any_clr = gl_wr && (gl_addr == AW'(2) || gl_addr == AW'(3));
    for (int r = 0; r < NREG; r++)
      if (rg_wr[r] && (rg_addr[r*AW +: AW] == AW'(2) || rg_addr[r*AW +: AW] == AW'(3)))
        any_clr = 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> pend == '0);

  assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> pend[$past(evt_code)]);

  assert_no_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_clr |=> ((~pend & $past(pend)) == '0));

  assert_no_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> ((pend & ~$past(pend)) == '0));

  assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> $countones(pend & ~$past(pend)) <= 1);

  assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> ($past(pend) != '0));
endmodule

bind cmpl_irq_ctrl cmpl_irq_ctrl_chk #(.NREG(NREG), .CODE_W(CODE_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
  .rg_wr(rg_wr), .rg_addr(rg_addr), .gl_wr(gl_wr), .gl_addr(gl_addr),
  .irq(irq), .pend(pend_q)
);

// File: tb/cmpl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cmpl_irq_ctrl_bench;
  localparam int NREG = 8, AW = 3, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [5:0] evt_code = '0;
  logic [NREG-1:0] rg_wr;
  logic [NREG*AW-1:0] rg_addr;
  logic [NREG*DW-1:0] rg_wdata, rg_rdata;
  logic gl_wr = 1'b0;
  logic [AW-1:0] gl_addr = '0;
  logic [DW-1:0] gl_wdata = '0, gl_rdata;
  logic [NREG-1:0] irq;

  logic          b_wr [NREG];
  logic [AW-1:0] b_addr [NREG];
  logic [DW-1:0] b_data [NREG];

  always_comb
    for (int r = 0; r < NREG; r++) begin
      rg_wr[r] = b_wr[r];
      rg_addr[r*AW +: AW] = b_addr[r];
      rg_wdata[r*DW +: DW] = b_data[r];
    end

  cmpl_irq_ctrl u_cmpl_irq_ctrl (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  logic [63:0] m_pend = '0, m_gen = '0;
  logic [63:0] m_en [NREG];
  logic [NREG-1:0] m_irq = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_rd(input logic [AW-1:0] a, input logic [63:0] e);
    case (a)
      3'd0: return m_pend[31:0];
      3'd1: return m_pend[63:32];
      3'd4: return e[31:0];
      3'd5: return e[63:32];
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    if (a <= 3'd1) return "R1";
    if (a == 3'd4 || a == 3'd5) return "R7";
    return "R9";
  endfunction

  task automatic compare_all();
    for (int r = 0; r < NREG; r++)
      check(tag_of(b_addr[r]), 64'(rg_rdata[r*DW +: DW]), 64'(m_rd(b_addr[r], m_en[r])));
    check(tag_of(gl_addr), 64'(gl_rdata), 64'(m_rd(gl_addr, m_gen)));
    check("R6", 64'(irq), 64'(m_irq));
  endtask

  function automatic logic [63:0] wmask(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    if (w && a == 3'd2) return {32'd0, d};
    if (w && a == 3'd3) return {d, 32'd0};
    return '0;
  endfunction

  task automatic model_edge();
    logic [63:0] clr, nxt;
    logic [NREG-1:0] ni;
    if (!rst_n) begin
      m_pend = '0; m_gen = '0; m_irq = '0;
      for (int r = 0; r < NREG; r++) m_en[r] = '0;
      return;
    end
    clr = wmask(gl_wr, gl_addr, gl_wdata);
    for (int r = 0; r < NREG; r++) begin
      clr |= wmask(b_wr[r], b_addr[r], b_data[r]);
      ni[r] = |(m_pend & m_en[r] & m_gen);
    end
    nxt = m_pend & ~clr;
    if (evt_valid) nxt[evt_code] = 1'b1;
    for (int r = 0; r < NREG; r++) begin
      if (b_wr[r] && b_addr[r] == 3'd4) m_en[r][31:0] = b_data[r];
      if (b_wr[r] && b_addr[r] == 3'd5) m_en[r][63:32] = b_data[r];
    end
    if (gl_wr && gl_addr == 3'd4) m_gen[31:0] = gl_wdata;
    if (gl_wr && gl_addr == 3'd5) m_gen[63:32] = gl_wdata;
    m_pend = nxt;
    m_irq = ni;
  endtask

  task automatic idle();
    evt_valid = 1'b0; gl_wr = 1'b0;
    for (int r = 0; r < NREG; r++) b_wr[r] = 1'b0;
  endtask

  task automatic step();
    #1 compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    idle();
  endtask

  task automatic rgw(input int r, input logic [AW-1:0] a, input logic [31:0] d);
    b_wr[r] = 1'b1; b_addr[r] = a; b_data[r] = d;
  endtask

  task automatic glw(input logic [AW-1:0] a, input logic [31:0] d);
    gl_wr = 1'b1; gl_addr = a; gl_wdata = d;
  endtask

  task automatic evt(input logic [5:0] c);
    evt_valid = 1'b1; evt_code = c;
  endtask

  task automatic pend_is(input string tag, input logic [63:0] exp);
    logic [63:0] got;
    #1 gl_addr = 3'd0;
    #1 got[31:0] = gl_rdata;
    gl_addr = 3'd1;
    #1 got[63:32] = gl_rdata;
    check(tag, got, exp);
    gl_addr = 3'd0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin
      b_wr[r] = 1'b0; b_addr[r] = AW'(r % 6); b_data[r] = '0; m_en[r] = '0;
    end
    @(negedge clk);
    repeat (3) step();
    rst_n = 1'b1;
    pend_is("R1 reset", 64'd0);
    step();

    rgw(0, 3'd0, 32'hFFFF_FFFF); rgw(1, 3'd1, 32'hFFFF_FFFF); step();
    pend_is("R2 write to pending", 64'd0);

    evt(6'd3); step(); evt(6'd4); step(); evt(6'd40); step();
    evt(6'd63); step(); evt(6'd0); step();
    pend_is("R4 events", 64'h8000_0100_0000_0019);

    glw(3'd4, 32'h0000_0008); rgw(0, 3'd4, 32'h0000_0008); step();
    rgw(2, 3'd5, 32'h0000_0100); step();
    glw(3'd5, 32'h8000_0100); step();
    step(); step();
    check("R6 irq after enable", 64'(irq), 64'h0000_0000_0000_0005);
    check("R7 other region mask untouched", 64'(m_en[1]), 64'd0);

    rgw(0, 3'd2, 32'h0000_0009); step();
    pend_is("R3 clear low", 64'h8000_0100_0000_0010);
    step();
    check("R6 irq drop", 64'(irq), 64'h0000_0000_0000_0004);

    evt(6'd4); rgw(3, 3'd2, 32'h0000_0010); step();
    pend_is("R5 set beats clear", 64'h8000_0100_0000_0010);

    rgw(1, 3'd3, 32'h8000_0000); rgw(2, 3'd3, 32'h0000_0100); glw(3'd2, 32'h0000_0010);
    step();
    pend_is("R8 simultaneous clears", 64'd0);
    step(); step();
    check("R6 irq all low", 64'(irq), 64'd0);

    evt(6'd7); rgw(4, 3'd6, 32'hFFFF_FFFF); step();
    pend_is("R9 unused write", 64'h80);
    rgw(5, 3'd2, 32'h0); rgw(6, 3'd3, 32'hFFFF_FFFF); step();
    pend_is("R3 zero keeps", 64'h80);

    glw(3'd4, 32'hFFFF_FFFF); step(); glw(3'd5, 32'hFFFF_FFFF); step();
    for (int k = 0; k < 2000; k++) begin
      if ($urandom_range(0, 2) == 0) evt(6'($urandom_range(0, 63)));
      for (int r = 0; r < NREG; r++) begin
        b_addr[r] = AW'($urandom_range(0, 7));
        b_data[r] = $urandom();
        b_wr[r] = ($urandom_range(0, 3) == 0);
      end
      gl_addr = AW'($urandom_range(0, 7));
      gl_wdata = $urandom();
      gl_wr = ($urandom_range(0, 7) == 0);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule